// File: doc/BRIEF.md
# One-Hot Sequenced Wrapping Counter

This block is the hardware form of a tiny looping program: an unsigned variable is incremented, a one-cycle delay statement follows, and the loop starts over. Program control is a chain of three D flip-flops with exactly one hot at a time: a start stage, an increment stage and a delay stage. Each bit of the variable lives in its own toggle flip-flop. A ripple-carry chain, enabled only by the increment stage, decides which bits toggle.

Every flip-flop has one common clock. Each next value is a sum-of-products of flip-flop outputs, so the only external inputs are the clock and the reset. The variable holds each value for two cycles, because the delay stage sits between increments. The outputs show the variable and the one-hot stage vector, so surrounding logic can watch the program's progress.

Top module: `oh_mod_counter`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises but before any clock edge, `stage_o` is 3'b000 and `count_o` is 0.
- R2: The first clock edge after reset release sets the start stage alone (`stage_o` = 3'b001, bit 0). The start stage is never set again until the next reset.
- R3: From the start cycle onward, exactly one bit of `stage_o` is 1 in every cycle.
- R4: Control moves start → increment (bit 1, 3'b010) → delay (bit 2, 3'b100) → increment → delay, and so on, one step per clock edge.
- R5: `count_o` changes only on the clock edge that ends an increment-stage cycle. On every other edge it holds.
- R6: On the edge that ends an increment-stage cycle, `count_o` becomes its old value plus one, modulo 2^CNT_W. With the default CNT_W = 2 this wraps from 3 to 0.
- R7: Sampled once per cycle starting at the start cycle, `count_o` reads 0,0,1,1,2,2,3,3 and then repeats. In general, after clock edge k (k ≥ 1) it equals floor((k−1)/2) mod 2^CNT_W.
- R8: Bit i of `count_o` toggles exactly when the increment stage is hot and all bits below i are 1. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for every flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset that clears all flip-flops |
| count_o | output | CNT_W | Current value of the counted variable |
| stage_o | output | 3 | One-hot control state: bit 0 start, bit 1 increment, bit 2 delay |

## Verification
Every result is due one clock edge after the state that causes it. The start stage appears after the first edge following reset release. A new count value appears after the edge that closes an increment cycle. The bench therefore counts edges since reset release and samples at the falling edge that follows each rising edge. It compares against the closed forms of R4 and R7, and it compares each sample with the one before it for R5, R6 and R8. A mid-run reset restarts the edge count at zero, so the same expectations apply again after release.

// File: rtl/oh_cnt_pkg.sv
`timescale 1ns/1ps
package oh_cnt_pkg;
    localparam int NUM_STG  = 3;
    localparam int STG_INIT = 0;
    localparam int STG_INC  = 1;
    localparam int STG_DLY  = 2;

    typedef logic [NUM_STG-1:0] stage_vec_t;

    typedef struct packed {
        stage_vec_t stage;
    } ctrl_regs_t;
endpackage

// File: rtl/oh_seq_ctrl.sv
`timescale 1ns/1ps
module oh_seq_ctrl
    import oh_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output stage_vec_t stage_o
);
    ctrl_regs_t ctrl_d, ctrl_q;

    // Start stage fires only when no stage is hot, which is true solely after reset.
    always_comb begin
        ctrl_d = ctrl_q;
        ctrl_d.stage[STG_INIT] = ~|ctrl_q.stage;
        ctrl_d.stage[STG_INC]  = ctrl_q.stage[STG_INIT] | ctrl_q.stage[STG_DLY];
        ctrl_d.stage[STG_DLY]  = ctrl_q.stage[STG_INC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign stage_o = ctrl_q.stage;

    // R3: once any stage is hot, exactly one stays hot
    assert_stage_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.stage != '0) |=> ($countones(ctrl_q.stage) == 1));

    // R2: start stage lasts one cycle and hands over to the increment stage
    assert_start_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.stage[STG_INIT] |=> (!ctrl_q.stage[STG_INIT] && ctrl_q.stage[STG_INC]));

    // R2: after any non-start stage the start stage stays clear
    assert_start_never_again_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.stage != '0 && !ctrl_q.stage[STG_INIT]) |=> !ctrl_q.stage[STG_INIT]);

    // R4: delay is followed by increment, then delay again
    assert_loop_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.stage[STG_DLY] |=> ctrl_q.stage[STG_INC] ##1 ctrl_q.stage[STG_DLY]);
endmodule

// File: rtl/oh_ripple_toggle.sv
`timescale 1ns/1ps
module oh_ripple_toggle #(
    parameter int CNT_W = 2,
    localparam int LOW_W = CNT_W - 1
) (
    input  logic             fire_i,
    input  logic [LOW_W-1:0] low_i,
    output logic [CNT_W-1:0] tgl_o
);
    logic [CNT_W-1:0] carry;

    assign carry[0] = fire_i;

    for (genvar i = 1; i < CNT_W; i++) begin : g_chain
        assign carry[i] = carry[i-1] & low_i[i-1];
    end

    assign tgl_o = carry;
endmodule

// File: rtl/oh_tff_bank.sv
`timescale 1ns/1ps
module oh_tff_bank #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tgl_i,
    output logic [CNT_W-1:0] q_o
);
    logic [CNT_W-1:0] bit_d, bit_q;

    for (genvar i = 0; i < CNT_W; i++) begin : g_tff
        always_comb begin
            bit_d[i] = tgl_i[i] ? ~bit_q[i] : bit_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q[i] <= 1'b0;
            else        bit_q[i] <= bit_d[i];
        end
    end

    assign q_o = bit_q;
endmodule

// File: rtl/oh_mod_counter.sv
`timescale 1ns/1ps
module oh_mod_counter
    import oh_cnt_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o,
    output logic [2:0]       stage_o
);
    localparam int LOW_W = CNT_W - 1;

    stage_vec_t       stage_q;
    logic [CNT_W-1:0] tgl;
    logic [CNT_W-1:0] count_q;

    oh_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_o (stage_q)
    );

    oh_ripple_toggle #(.CNT_W(CNT_W)) u_inc (
        .fire_i (stage_q[STG_INC]),
        .low_i  (count_q[LOW_W-1:0]),
        .tgl_o  (tgl)
    );

    oh_tff_bank #(.CNT_W(CNT_W)) u_var (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl_i (tgl),
        .q_o   (count_q)
    );

    assign count_o = count_q;
    assign stage_o = stage_q;

    // R5: the variable holds outside the increment stage
    assert_hold_outside_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_q[STG_INC] |=> $stable(count_q));

    // R6: an increment cycle adds one with wrap
    assert_add_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[STG_INC] |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R8: with bit 0 clear, no upper bit moves on an increment
    assert_carry_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q[STG_INC] && !count_q[0]) |=> $stable(count_q[CNT_W-1:1]));
endmodule

// File: tb/oh_mod_counter_tb.sv
`timescale 1ns/1ps
module oh_mod_counter_tb;
    localparam int W = 2;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_o;
    logic [2:0]   stage_o;

    int n_chk = 0;
    int n_fail = 0;
    int k = 0;
    bit done = 0;

    always #2 clk = ~clk;

    oh_mod_counter #(.CNT_W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count_o),
        .stage_o (stage_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, k);
        end
    endtask

    function automatic int exp_stage(input int e);
        if (e == 0) return 0;
        if (e == 1) return 1;
        return (e % 2 == 0) ? 2 : 4;
    endfunction

    function automatic int exp_count(input int e);
        if (e == 0) return 0;
        return ((e - 1) / 2) % MOD;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        k++;
    endtask

    // R1: reset holds everything at zero, also right after release
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(stage_o == 3'b000, "R1 stage in reset", stage_o, 0);
        check(count_o == '0, "R1 count in reset", count_o, 0);
        step();
        check(stage_o == 3'b000, "R1 stage held in reset", stage_o, 0);
        rst_n = 1'b1;
        k = 0;
        #0.5;
        check(stage_o == 3'b000, "R1 stage after release", stage_o, 0);
        check(count_o == '0, "R1 count after release", count_o, 0);
    endtask

    // R2, R3, R4, R7: run many loops and compare with closed forms
    task automatic t_sequence(input int edges);
        for (int i = 0; i < edges; i++) begin
            step();
            check(int'(stage_o) == exp_stage(k), "R4 stage order", stage_o, exp_stage(k));
            check($countones(stage_o) == 1, "R3 one-hot", $countones(stage_o), 1);
            if (k == 1) check(stage_o == 3'b001, "R2 start stage", stage_o, 1);
            else check(stage_o[0] == 1'b0, "R2 start never again", stage_o[0], 0);
            check(int'(count_o) == exp_count(k), "R7 count sequence", count_o, exp_count(k));
        end
    endtask

    // R5, R6, R8: compare each sample with the previous one
    task automatic t_increments(input int edges);
        logic [W-1:0] pv;
        logic [2:0]   ps;
        pv = count_o;
        ps = stage_o;
        for (int i = 0; i < edges; i++) begin
            step();
            if (ps[1]) begin
                check(count_o == W'(pv + 1'b1), "R6 add one", count_o, int'(W'(pv + 1'b1)));
            end else begin
                check(count_o == pv, "R5 hold", count_o, pv);
            end
            for (int b = 0; b < W; b++) begin
                bit lows = 1'b1;
                for (int j = 0; j < b; j++) lows &= pv[j];
                check((count_o[b] != pv[b]) == (ps[1] && lows), "R8 toggle rule",
                      count_o[b] ^ pv[b], ps[1] && lows);
            end
            pv = count_o;
            ps = stage_o;
        end
    endtask

    // R6 wrap: find the 3 -> 0 transition explicitly
    task automatic t_wrap();
        int guard = 0;
        while (!(stage_o == 3'b010 && count_o == W'(MOD - 1)) && guard < 40) begin
            step();
            guard++;
        end
        step();
        check(count_o == '0, "R6 wrap to zero", count_o, 0);
        check(stage_o == 3'b100, "R4 delay after wrap", stage_o, 4);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        t_sequence(3 * 2 * MOD + 5);
        t_increments(20);
        t_wrap();
        // Mid-run reset then restart
        t_reset();
        t_sequence(2 * 2 * MOD);
        t_increments(10);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule